// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block chooses the power mode of a small microcontroller-style system and turns that mode into a set of enable levels. The power domains, oscillators and retention memories sit outside the block. Software picks idle, standby or shutdown by pulsing a request strobe while the system is active. Each low-power mode then waits for its own set of wake sources. Idle returns on an interrupt. Standby returns on an RTC event, a sensor-controller event or a wake-pin edge. It passes through a wake-up phase that waits until the high-speed oscillator reports ready. Shutdown returns only on a wake-pin edge, and that return is a full system reset.

The external reset pin overrides every mode. While the pin is held, every enable is off, and releasing it produces a system reset. A three-bit one-hot reset-cause register records the most recent reset source: power-on, reset pin, or wake from shutdown. Software clears it bit by bit with a write-one-to-clear strobe. The I/O latch output freezes the pads while the system is in standby, in wake-up and in shutdown. In standby the brownout detector enable pulses on a fixed duty cycle. The watchdog is paused there, not cleared.

Top module: `lpm_sequencer`

## Requirements
- R1: The synchronous active-low power-on reset `rst_n` puts the block in the restart state (`mode_state` = 6) with `sys_reset` = 1 and `reset_cause` = 3'b001 (bit 0 = power-on). The first clock edge after release moves the block to active (`mode_state` = 0).
- R2: In active mode (`mode_state` = 0) these outputs are 1: CPU clock, flash, SRAM on, high-speed clock, medium-speed clock, low-speed clock, peripherals, brownout detector and watchdog run. These outputs are 0: SRAM retention, watchdog clear, I/O latch and `sys_reset`.
- R3: A mode request is accepted only in active mode. With `req_valid` = 1, a `req_mode` of 1 selects idle (`mode_state` = 1), 2 selects standby (`mode_state` = 2) and 3 selects shutdown (`mode_state` = 3), each on the clock edge that samples the strobe. A `req_mode` of 0 has no effect, and so does a request made in any other mode.
- R4: In idle the CPU clock is off while the flash, SRAM, all three clocks and the peripherals stay on. An `irq` returns the block to active on the next edge. RTC, sensor-controller and wake-pin events do not move it out of idle.
- R5: In standby the CPU clock, flash, SRAM on, high-speed clock, medium-speed clock and peripherals are off. SRAM retention, the low-speed clock and the I/O latch are on. Watchdog run and watchdog clear are both 0, which pauses the watchdog.
- R6: Standby is left only on `rtc_evt`, `sensor_evt` or `wake_edge`, each of which moves the block to the wake-up state (`mode_state` = 4). An `irq` or a mode request leaves it in standby.
- R7: In wake-up the high-speed, medium-speed and low-speed clocks are on, SRAM stays in retention, and the CPU clock and peripherals are off with the I/O latch still held. The block stays there until `hf_ready` = 1, and on that edge it returns to active, where the latch is released.
- R8: In standby `bod_en` is 1 in the first standby cycle and then once every 2^`BOD_DUTY_LOG2` cycles. It is 0 in the other standby cycles.
- R9: In shutdown (`mode_state` = 3) every clock and domain enable is 0, including the low-speed clock and the brownout detector. The I/O latch and watchdog clear are 1. Only `wake_edge` leaves shutdown: it moves the block to restart (`mode_state` = 6) and records `reset_cause` = 3'b100 (bit 2 = shutdown wake).
- R10: `rst_pin` = 1 moves the block from any state to the pin-hold state (`mode_state` = 5) on the next edge, ahead of any other input. In pin-hold every enable and the I/O latch are 0 and watchdog clear is 1. The first edge with the pin released moves the block to restart and records `reset_cause` = 3'b010 (bit 1 = reset pin).
- R11: Each 1 bit of `cause_clr` clears the matching `reset_cause` bit on the next edge. A newly recorded cause replaces the whole register and wins over a clear in the same cycle. `reset_cause` is never more than one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| rst_pin | input | 1 | External reset pin held (1 = held) |
| req_valid | input | 1 | Mode-request strobe |
| req_mode | input | 2 | Requested mode: 1 idle, 2 standby, 3 shutdown |
| irq | input | 1 | Enabled interrupt pending |
| rtc_evt | input | 1 | RTC event |
| sensor_evt | input | 1 | Sensor-controller event |
| wake_edge | input | 1 | Edge seen on a configured wake pin |
| hf_ready | input | 1 | High-speed oscillator ready acknowledge |
| cause_clr | input | 3 | Write-one-to-clear strobe for reset_cause |
| mode_state | output | 3 | Current state code (0 active … 6 restart) |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_en | output | 1 | Flash power enable |
| sram_on | output | 1 | SRAM fully powered |
| sram_ret | output | 1 | SRAM in retention |
| hf_clk_en | output | 1 | High-speed clock enable |
| mf_clk_en | output | 1 | Medium-speed clock enable |
| lf_clk_en | output | 1 | Low-speed clock enable |
| periph_en | output | 1 | Peripheral clock enable |
| bod_en | output | 1 | Brownout detector enable |
| wdt_run | output | 1 | Watchdog counting |
| wdt_clr | output | 1 | Watchdog held cleared |
| io_latch | output | 1 | Pads frozen at last value |
| sys_reset | output | 1 | System reset pulse |
| reset_cause | output | 3 | One-hot last reset cause |

## Verification
The bench sets `BOD_DUTY_LOG2` to 2, so the brownout enable pulses every four standby cycles. Nine consecutive standby samples therefore see three pulses and two counter wraps. The default of 3 would spread the same checks over a longer window. All other behaviour does not depend on the parameter. The vector walk takes every wake source through each mode that ignores it as well as the mode that accepts it. It also covers a clear that collides with a new cause, and a reset-pin press in every state, including during restart.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
// Shared types for the low-power mode sequencer.
// Assumes: state codes are visible at the top port and must stay fixed.
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_IDLE     = 3'd1,
        ST_STANDBY  = 3'd2,
        ST_SHUTDOWN = 3'd3,
        ST_WAKEUP   = 3'd4,
        ST_PINHOLD  = 3'd5,
        ST_RESTART  = 3'd6
    } lpm_state_e;

    localparam int          REQ_W        = 2;
    localparam logic [1:0]  REQ_IDLE     = 2'd1;
    localparam logic [1:0]  REQ_STANDBY  = 2'd2;
    localparam logic [1:0]  REQ_SHUTDOWN = 2'd3;

    localparam int CAUSE_W      = 3;
    localparam int CAUSE_POR    = 0;
    localparam int CAUSE_PIN    = 1;
    localparam int CAUSE_SDWAKE = 2;

    typedef struct packed {
        logic cpu_clk;
        logic flash;
        logic sram_on;
        logic sram_ret;
        logic hf_clk;
        logic mf_clk;
        logic lf_clk;
        logic periph;
        logic bod;
        logic wdt_run;
        logic wdt_clr;
        logic io_latch;
        logic sys_reset;
    } lpm_en_t;

endpackage

// File: rtl/lpm_mode_fsm.sv
`timescale 1ns/1ps
// Mode state machine: holds the current power state and picks the next one
// from requests and wake sources. Reset pin has top priority.
// Assumes: all inputs are synchronous to clk; wake_edge is already an edge pulse.
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rst_pin,
    input  logic                 req_valid,
    input  logic [REQ_W-1:0]     req_mode,
    input  logic                 irq,
    input  logic                 rtc_evt,
    input  logic                 sensor_evt,
    input  logic                 wake_edge,
    input  logic                 hf_ready,
    output lpm_state_e           state_q,
    output logic                 restart_by_pin,
    output logic                 restart_by_wake
);

    lpm_state_e state_d;
    logic       standby_wake;

    assign standby_wake = rtc_evt | sensor_evt | wake_edge;

    // Next-state selection; reset pin overrides every state.
    always_comb begin
        state_d = state_q;
        if (rst_pin) begin
            state_d = ST_PINHOLD;
        end else begin
            case (state_q)
                ST_ACTIVE: begin
                    if (req_valid) begin
                        case (req_mode)
                            REQ_IDLE:     state_d = ST_IDLE;
                            REQ_STANDBY:  state_d = ST_STANDBY;
                            REQ_SHUTDOWN: state_d = ST_SHUTDOWN;
                            default:      state_d = ST_ACTIVE;
                        endcase
                    end
                end
                ST_IDLE:     if (irq)          state_d = ST_ACTIVE;
                ST_STANDBY:  if (standby_wake) state_d = ST_WAKEUP;
                ST_WAKEUP:   if (hf_ready)     state_d = ST_ACTIVE;
                ST_SHUTDOWN: if (wake_edge)    state_d = ST_RESTART;
                ST_PINHOLD:  state_d = ST_RESTART;
                ST_RESTART:  state_d = ST_ACTIVE;
                default:     state_d = ST_RESTART;
            endcase
        end
    end

    // State register; power-on reset lands in restart.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESTART;
        else        state_q <= state_d;
    end

    // Reset-source flags for the cause register.
    assign restart_by_pin  = (state_q == ST_PINHOLD)  && (state_d == ST_RESTART);
    assign restart_by_wake = (state_q == ST_SHUTDOWN) && (state_d == ST_RESTART);

    AST_RESTART_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESTART && !rst_pin) |=> (state_q == ST_ACTIVE)); // R1
    AST_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && req_valid && req_mode == REQ_IDLE && !rst_pin) |=> (state_q == ST_IDLE)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !irq && !rst_pin) |=> (state_q == ST_IDLE)); // R4
    AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && !rtc_evt && !sensor_evt && !wake_edge && !rst_pin) |=> (state_q == ST_STANDBY)); // R6
    AST_WAKEUP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKEUP && !hf_ready && !rst_pin) |=> (state_q == ST_WAKEUP)); // R7
    AST_SHUTDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHUTDOWN && !wake_edge && !rst_pin) |=> (state_q == ST_SHUTDOWN)); // R9
    AST_PIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin |=> (state_q == ST_PINHOLD)); // R10

endmodule

// File: rtl/lpm_enable_decode.sv
`timescale 1ns/1ps
// Enable decoder: maps the current state to domain, clock and pad controls,
// and duty-cycles the brownout detector while in standby.
// Assumes: state is registered, so outputs are glitch-free at the state boundary.
module lpm_enable_decode
    import lpm_pkg::*;
#(
    parameter int DUTY_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  lpm_state_e state,
    output lpm_en_t    en
);

    logic bod_tick;

    generate
        if (DUTY_LOG2 > 0) begin : g_duty
            logic [DUTY_LOG2-1:0] duty_q;
            // Phase counter that restarts on every entry to standby.
            always_ff @(posedge clk) begin
                if (!rst_n || state != ST_STANDBY) duty_q <= '0;
                else                               duty_q <= duty_q + 1'b1;
            end
            assign bod_tick = (duty_q == '0);
        end else begin : g_cont
            assign bod_tick = 1'b1;
        end
    endgenerate

    // Per-state enable pattern.
    always_comb begin
        en = '0;
        case (state)
            ST_ACTIVE: begin
                en.cpu_clk = 1'b1; en.flash  = 1'b1; en.sram_on = 1'b1;
                en.hf_clk  = 1'b1; en.mf_clk = 1'b1; en.lf_clk  = 1'b1;
                en.periph  = 1'b1; en.bod    = 1'b1; en.wdt_run = 1'b1;
            end
            ST_IDLE: begin
                en.flash   = 1'b1; en.sram_on = 1'b1;
                en.hf_clk  = 1'b1; en.mf_clk  = 1'b1; en.lf_clk = 1'b1;
                en.periph  = 1'b1; en.bod     = 1'b1; en.wdt_run = 1'b1;
            end
            ST_STANDBY: begin
                en.sram_ret = 1'b1; en.lf_clk = 1'b1;
                en.bod      = bod_tick; en.io_latch = 1'b1;
            end
            ST_WAKEUP: begin
                en.sram_ret = 1'b1; en.hf_clk = 1'b1; en.mf_clk = 1'b1;
                en.lf_clk   = 1'b1; en.bod    = 1'b1; en.io_latch = 1'b1;
            end
            ST_SHUTDOWN: begin
                en.io_latch = 1'b1; en.wdt_clr = 1'b1;
            end
            ST_PINHOLD: begin
                en.wdt_clr = 1'b1;
            end
            ST_RESTART: begin
                en.wdt_clr = 1'b1; en.sys_reset = 1'b1;
            end
            default: begin
                en.wdt_clr = 1'b1; en.sys_reset = 1'b1;
            end
        endcase
    end

    AST_SRAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(en.sram_on && en.sram_ret)); // R5
    AST_LATCH_NO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        en.io_latch |-> !en.cpu_clk && !en.periph); // R5
    AST_CPU_NEEDS_HF: assert property (@(posedge clk) disable iff (!rst_n)
        en.cpu_clk |-> en.hf_clk); // R7
    AST_WDT_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY) |-> !en.wdt_run && !en.wdt_clr); // R5
    AST_SHUTDOWN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHUTDOWN) |-> !en.lf_clk && !en.bod && en.io_latch); // R9

endmodule

// File: rtl/lpm_reset_cause.sv
`timescale 1ns/1ps
// Reset-cause register: one-hot record of the latest reset source with a
// write-one-to-clear strobe. A new cause replaces the old and beats a clear.
// Assumes: the set flags never fire together.
module lpm_reset_cause
    import lpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_pin,
    input  logic               set_wake,
    input  logic [CAUSE_W-1:0] clr,
    output logic [CAUSE_W-1:0] cause_q
);

    // Record, replace or clear the cause bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_W'(1) << CAUSE_POR;
        end else if (set_pin) begin
            cause_q <= CAUSE_W'(1) << CAUSE_PIN;
        end else if (set_wake) begin
            cause_q <= CAUSE_W'(1) << CAUSE_SDWAKE;
        end else begin
            cause_q <= cause_q & ~clr;
        end
    end

    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_q)); // R11
    AST_PIN_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        set_pin |=> cause_q[CAUSE_PIN]); // R10
    AST_WAKE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        set_wake |=> cause_q[CAUSE_SDWAKE]); // R9

endmodule

// File: rtl/lpm_sequencer.sv
`timescale 1ns/1ps
// Low-power mode sequencer top: state machine, enable decoder and reset-cause
// register wired together and flattened onto plain ports.
// Assumes: one clock domain that keeps running in every mode.
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int BOD_DUTY_LOG2 = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_pin,
    input  logic               req_valid,
    input  logic [REQ_W-1:0]   req_mode,
    input  logic               irq,
    input  logic               rtc_evt,
    input  logic               sensor_evt,
    input  logic               wake_edge,
    input  logic               hf_ready,
    input  logic [CAUSE_W-1:0] cause_clr,
    output logic [2:0]         mode_state,
    output logic               cpu_clk_en,
    output logic               flash_en,
    output logic               sram_on,
    output logic               sram_ret,
    output logic               hf_clk_en,
    output logic               mf_clk_en,
    output logic               lf_clk_en,
    output logic               periph_en,
    output logic               bod_en,
    output logic               wdt_run,
    output logic               wdt_clr,
    output logic               io_latch,
    output logic               sys_reset,
    output logic [CAUSE_W-1:0] reset_cause
);

    lpm_state_e state;
    lpm_en_t    en;
    logic       restart_by_pin;
    logic       restart_by_wake;

    lpm_mode_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .rst_pin         (rst_pin),
        .req_valid       (req_valid),
        .req_mode        (req_mode),
        .irq             (irq),
        .rtc_evt         (rtc_evt),
        .sensor_evt      (sensor_evt),
        .wake_edge       (wake_edge),
        .hf_ready        (hf_ready),
        .state_q         (state),
        .restart_by_pin  (restart_by_pin),
        .restart_by_wake (restart_by_wake)
    );

    lpm_enable_decode #(.DUTY_LOG2(BOD_DUTY_LOG2)) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .en    (en)
    );

    lpm_reset_cause u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_pin  (restart_by_pin),
        .set_wake (restart_by_wake),
        .clr      (cause_clr),
        .cause_q  (reset_cause)
    );

    assign mode_state = state;
    assign cpu_clk_en = en.cpu_clk;
    assign flash_en   = en.flash;
    assign sram_on    = en.sram_on;
    assign sram_ret   = en.sram_ret;
    assign hf_clk_en  = en.hf_clk;
    assign mf_clk_en  = en.mf_clk;
    assign lf_clk_en  = en.lf_clk;
    assign periph_en  = en.periph;
    assign bod_en     = en.bod;
    assign wdt_run    = en.wdt_run;
    assign wdt_clr    = en.wdt_clr;
    assign io_latch   = en.io_latch;
    assign sys_reset  = en.sys_reset;

    AST_RESET_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |-> (reset_cause != '0)); // R11

endmodule

// File: tb/test_lpm_sequencer.sv
`timescale 1ns/1ps
module test_lpm_sequencer;

    localparam int DUTY = 2;
    localparam int NV   = 59;
    localparam int WDOG = 20000;

    logic       clk = 1'b0;
    logic       rst_n, rst_pin, req_valid, irq, rtc_evt, sensor_evt, wake_edge, hf_ready;
    logic [1:0] req_mode;
    logic [2:0] cause_clr, mode_state, reset_cause;
    logic       cpu_clk_en, flash_en, sram_on, sram_ret, hf_clk_en, mf_clk_en, lf_clk_en;
    logic       periph_en, bod_en, wdt_run, wdt_clr, io_latch, sys_reset;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    lpm_sequencer #(.BOD_DUTY_LOG2(DUTY)) i_lpm_sequencer (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .req_valid(req_valid),
        .req_mode(req_mode), .irq(irq), .rtc_evt(rtc_evt), .sensor_evt(sensor_evt),
        .wake_edge(wake_edge), .hf_ready(hf_ready), .cause_clr(cause_clr),
        .mode_state(mode_state), .cpu_clk_en(cpu_clk_en), .flash_en(flash_en),
        .sram_on(sram_on), .sram_ret(sram_ret), .hf_clk_en(hf_clk_en),
        .mf_clk_en(mf_clk_en), .lf_clk_en(lf_clk_en), .periph_en(periph_en),
        .bod_en(bod_en), .wdt_run(wdt_run), .wdt_clr(wdt_clr), .io_latch(io_latch),
        .sys_reset(sys_reset), .reset_cause(reset_cause)
    );

    // Vector: pin rv mode irq rtc sens wake hfr clr[3] | exp_state[3] exp_cause[3]
    localparam logic [17:0] VEC [0:NV-1] = '{
        18'b0_0_00_0_0_0_0_0_000_000_001, // R2 steady active
        18'b0_0_00_1_0_0_0_0_000_000_001, // R3 irq in active
        18'b0_1_00_0_0_0_0_0_000_000_001, // R3 mode code 0 ignored
        18'b0_0_00_0_0_0_0_0_010_000_001, // R11 clearing an unset bit
        18'b0_1_01_0_0_0_0_0_000_001_001, // R3 idle request
        18'b0_0_00_0_1_0_0_0_000_001_001, // R4 rtc ignored in idle
        18'b0_0_00_0_0_1_1_0_000_001_001, // R4 sensor/wake ignored in idle
        18'b0_1_10_0_0_0_0_0_000_001_001, // R3 request ignored in idle
        18'b0_0_00_1_0_0_0_0_000_000_001, // R4 irq exits idle
        18'b0_1_10_0_0_0_0_0_000_010_001, // R3 standby request
        18'b0_0_00_1_0_0_0_0_000_010_001, // R6 irq ignored in standby
        18'b0_1_11_0_0_0_0_1_000_010_001, // R6 request and hf_ready ignored
        18'b0_0_00_0_1_0_0_0_000_100_001, // R6 rtc wakes
        18'b0_0_00_0_0_0_0_0_000_100_001, // R7 waits for hf_ready
        18'b0_1_01_0_0_0_0_0_000_100_001, // R7 request ignored in wake-up
        18'b0_0_00_0_0_0_0_1_000_000_001, // R7 hf_ready -> active
        18'b0_1_10_0_0_0_0_0_000_010_001, // R3
        18'b0_0_00_0_0_1_0_0_000_100_001, // R6 sensor event wakes
        18'b0_0_00_0_0_0_0_1_000_000_001, // R7
        18'b0_1_10_0_0_0_0_0_000_010_001, // R3
        18'b0_0_00_0_0_0_1_0_000_100_001, // R6 wake pin wakes
        18'b0_0_00_0_0_0_0_1_000_000_001, // R7
        18'b0_1_11_0_0_0_0_0_000_011_001, // R3 shutdown request
        18'b0_0_00_1_1_1_0_1_000_011_001, // R9 other sources ignored
        18'b0_1_01_0_0_0_0_0_000_011_001, // R9 request ignored
        18'b0_0_00_0_0_0_1_0_000_110_100, // R9 wake pin -> restart, cause overwrite R11
        18'b0_0_00_0_0_0_0_0_000_000_100, // R1 restart -> active
        18'b1_0_00_0_0_0_0_0_000_101_100, // R10 pin held
        18'b1_0_00_0_0_0_1_0_000_101_100, // R10 wake ignored while held
        18'b0_0_00_0_0_0_0_0_000_110_010, // R10 release -> restart
        18'b0_0_00_0_0_0_0_0_000_000_010, // R1
        18'b0_0_00_0_0_0_0_0_100_000_010, // R11 clear other bit
        18'b0_0_00_0_0_0_0_0_010_000_000, // R11 clear set bit
        18'b0_1_10_0_0_0_0_0_000_010_000, // R3
        18'b1_0_00_0_0_0_0_0_000_101_000, // R10 from standby
        18'b0_0_00_0_0_0_0_0_000_110_010, // R10
        18'b0_0_00_0_0_0_0_0_000_000_010, // R1
        18'b0_1_01_0_0_0_0_0_000_001_010, // R3
        18'b1_0_00_0_0_0_0_0_000_101_010, // R10 from idle
        18'b0_0_00_0_0_0_0_0_000_110_010, // R10
        18'b0_0_00_0_0_0_0_0_000_000_010, // R1
        18'b0_0_00_0_0_0_0_0_111_000_000, // R11 clear all
        18'b0_1_11_0_0_0_0_0_000_011_000, // R3
        18'b1_0_00_0_0_0_0_0_000_101_000, // R10 from shutdown
        18'b0_0_00_0_0_0_0_0_010_110_010, // R11 set beats clear
        18'b0_0_00_0_0_0_0_0_000_000_010, // R1
        18'b0_1_10_0_0_0_0_0_000_010_010, // R3
        18'b0_0_00_0_1_0_0_0_000_100_010, // R6
        18'b1_0_00_0_0_0_0_0_000_101_010, // R10 from wake-up
        18'b0_0_00_0_0_0_0_0_000_110_010, // R10
        18'b0_0_00_0_0_0_0_0_000_000_010, // R1
        18'b1_1_01_0_0_0_0_0_000_101_010, // R10 pin beats request
        18'b0_0_00_0_0_0_0_0_000_110_010, // R10
        18'b0_0_00_0_0_0_0_0_000_000_010, // R1
        18'b1_0_00_0_0_0_0_0_000_101_010, // R10
        18'b0_0_00_0_0_0_0_0_000_110_010, // R10
        18'b1_0_00_0_0_0_0_0_000_101_010, // R10 pin during restart
        18'b0_0_00_0_0_0_0_0_000_110_010, // R10
        18'b0_0_00_0_0_0_0_0_000_000_010  // R1
    };

    // Expected enables {cpu,flash,sram_on,sram_ret,hf,mf,lf,periph,bod,wdt_run,wdt_clr,io_latch,sys_reset}
    function automatic logic [12:0] exp_en(input logic [2:0] st);
        case (st)
            3'd0:    return 13'b1_1_1_0_1_1_1_1_1_1_0_0_0; // R2
            3'd1:    return 13'b0_1_1_0_1_1_1_1_1_1_0_0_0; // R4
            3'd2:    return 13'b0_0_0_1_0_0_1_0_0_0_0_1_0; // R5 (bod masked)
            3'd3:    return 13'b0_0_0_0_0_0_0_0_0_0_1_1_0; // R9
            3'd4:    return 13'b0_0_0_1_1_1_1_0_1_0_0_1_0; // R7
            3'd5:    return 13'b0_0_0_0_0_0_0_0_0_0_1_0_0; // R10
            default: return 13'b0_0_0_0_0_0_0_0_0_0_1_0_1; // R1
        endcase
    endfunction

    function automatic string state_tag(input logic [2:0] st);
        case (st)
            3'd0: return "R3"; 3'd1: return "R4"; 3'd2: return "R6";
            3'd3: return "R9"; 3'd4: return "R7"; 3'd5: return "R10";
            default: return "R1";
        endcase
    endfunction

    function automatic string en_tag(input logic [2:0] st);
        case (st)
            3'd0: return "R2"; 3'd1: return "R4"; 3'd2: return "R5";
            3'd3: return "R9"; 3'd4: return "R7"; 3'd5: return "R10";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_outputs(input logic [2:0] st);
        logic [12:0] act;
        logic [12:0] exp;
        act = {cpu_clk_en, flash_en, sram_on, sram_ret, hf_clk_en, mf_clk_en, lf_clk_en,
               periph_en, bod_en, wdt_run, wdt_clr, io_latch, sys_reset};
        exp = exp_en(st);
        if (st == 3'd2) begin
            act[4] = 1'b0;
            exp[4] = 1'b0;
        end
        chk(en_tag(st), "enables", int'(act), int'(exp));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rst_pin = 1'b0; req_valid = 1'b0; req_mode = 2'd0;
        irq = 1'b0; rtc_evt = 1'b0; sensor_evt = 1'b0; wake_edge = 1'b0;
        hf_ready = 1'b0; cause_clr = 3'd0;

        // R1: state during power-on reset
        @(posedge clk); @(posedge clk); #1;
        chk("R1", "state in reset", int'(mode_state), 6);
        chk("R1", "cause in reset", int'(reset_cause), 1);
        chk_outputs(3'd6);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "state after reset", int'(mode_state), 0);
        chk_outputs(3'd0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rst_pin    = VEC[i][17];
            req_valid  = VEC[i][16];
            req_mode   = VEC[i][15:14];
            irq        = VEC[i][13];
            rtc_evt    = VEC[i][12];
            sensor_evt = VEC[i][11];
            wake_edge  = VEC[i][10];
            hf_ready   = VEC[i][9];
            cause_clr  = VEC[i][8:6];
            @(posedge clk); #1;
            chk(state_tag(VEC[i][5:3]), $sformatf("vector %0d state", i),
                int'(mode_state), int'(VEC[i][5:3]));
            chk("R11", $sformatf("vector %0d cause", i), int'(reset_cause), int'(VEC[i][2:0]));
            chk_outputs(VEC[i][5:3]);
        end

        // R8: brownout duty cycle in standby
        @(negedge clk);
        rst_pin = 1'b0; irq = 1'b0; rtc_evt = 1'b0; sensor_evt = 1'b0;
        wake_edge = 1'b0; hf_ready = 1'b0; cause_clr = 3'd0;
        req_valid = 1'b1; req_mode = 2'd2;
        @(posedge clk); #1;
        @(negedge clk) req_valid = 1'b0;
        for (int k = 0; k < 9; k++) begin
            chk("R8", $sformatf("bod_en standby cycle %0d", k), int'(bod_en),
                (k % (1 << DUTY) == 0) ? 1 : 0);
            @(posedge clk); #1;
        end
        chk("R6", "still standby", int'(mode_state), 2);

        // R1: power-on reset mid-run overwrites the cause
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1", "por state", int'(mode_state), 6);
        chk("R1", "por cause", int'(reset_cause), 1);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "por release", int'(mode_state), 0);

        summary();
        $finish;
    end

endmodule